// File: doc/BRIEF.md
# Infrared Raw Symbol Capture Receiver

This block watches a demodulated infrared line and records each symbol as a pair of durations. A symbol starts when the line falls. The low time comes first (the mark) and the high time follows (the space). The symbol ends at the next fall of the line. Both durations are counted in 10 µs ticks. A 1 µs strobe is made by dividing the clock by a programmable factor, and dividing that strobe by ten gives the tick.

If the mark plus the space reaches a programmable maximum width, the symbol is closed early. The receiver then treats the line as idle and raises a timeout flag. Each finished pair goes into a receive FIFO as one 32-bit word.

Software drives the block over a simple register bus. That bus enables the block, writes the configuration once the settling window has passed, arms capture, drains the FIFO and handles three interrupt sources: received, timeout and overflow. Together they drive one level-sensitive interrupt line.

Top module: `ir_symbol_rx`

## Requirements
- R1: After reset the registers read as follows. Enable (0x00) reads 0. Config (0x04) reads 0x3E80_0080, which is a maximum width of 0x3E80 with the raw bit 7 set. Mask (0x28) reads 0x7. Count (0x20) reads 0. Status (0x2C) reads 0. `irq` is low.
- R2: Writing 1 to enable bit 0 while the block is disabled makes busy (0x1C) read 1 for SETTLE_CYCLES clocks. A config write made while busy reads 1 is ignored. Once busy reads 0, a config write is accepted and reads back.
- R3: Line activity is ignored until some value is written to start (0x34) while the block is enabled.
- R4: The FIFO word carries the mark tick count in bits 15:0 and the space tick count in bits 31:16. A tick lasts 10×(F+1) clocks, where F is config bits 6:0. The counting restarts at every edge. A symbol is pushed when the line falls after its space.
- R5: The symbol is pushed early when mark+space reaches the maximum width in config bits 31:16. Early closure can happen in the mark phase, giving space 0, or in the space phase. It sets the timeout flag (status bit 9). The receiver then waits for a fresh falling edge.
- R6: Count (0x20) returns the number of stored words. Each read of data (0x24) pops the oldest word. A data read on an empty FIFO returns 0 and changes nothing.
- R7: The received flag (status bit 8) is set while the stored count exceeds config bits 13:8.
- R8: A push into a full FIFO is dropped and sets the overflow flag (status bit 10). The stored words stay intact and come out in order.
- R9: Writing 1 to bit 16, 17 or 18 of clear (0x30) clears the received, timeout or overflow flag respectively. Writing 0 to those bits changes nothing.
- R10: Mask bits 2:0 mask the received, timeout and overflow flags. Status bits 26:24 show the flags that are unmasked. `irq` is the OR of status bits 26:24.
- R11: Writing 0 to enable bit 0 disarms capture. No symbols are stored while the block is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated infrared line, idle high |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
A wrong tick phase or a miscounted edge shows up as a wrong mark or space field in the very next word read from the data register. The errors are off-by-one in ticks, which is why the bench holds each phase for half a tick beyond a whole number of ticks. A state machine stuck in the wrong phase shows up within one maximum-width window, either as a missing timeout flag or as a word with swapped fields. FIFO pointer or count faults show up as out-of-order or duplicated words once the FIFO is filled past its depth and then drained.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MARK, ST_SPACE} irrx_state_e;

  localparam logic [7:0] A_EN    = 8'h00;
  localparam logic [7:0] A_CFG   = 8'h04;
  localparam logic [7:0] A_BUSY  = 8'h1C;
  localparam logic [7:0] A_COUNT = 8'h20;
  localparam logic [7:0] A_DATA  = 8'h24;
  localparam logic [7:0] A_MASK  = 8'h28;
  localparam logic [7:0] A_STAT  = 8'h2C;
  localparam logic [7:0] A_CLR   = 8'h30;
  localparam logic [7:0] A_START = 8'h34;

  localparam logic [31:0] CFG_RESET = {16'h3E80, 2'b00, 6'd0, 1'b1, 7'd0};

  function automatic logic [31:0] pack_symbol(input logic [15:0] mark, input logic [15:0] space);
    return {space, mark};
  endfunction

  function automatic logic reaches_max(input logic [15:0] mark, input logic [15:0] space,
                                       input logic [15:0] maxw);
    return ({1'b0, mark} + {1'b0, space}) >= {1'b0, maxw};
  endfunction
endpackage

// File: rtl/irrx_tickgen.sv
module irrx_tickgen #(
  parameter int US_PER_TICK = 10,
  localparam int TW = $clog2(US_PER_TICK)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [6:0] freq_m1,
  output logic       tick
);
  logic [6:0]    us_cnt;
  logic [TW-1:0] ten_cnt;
  logic          us_str;

  assign us_str = (us_cnt == freq_m1);
  assign tick   = run && !restart && us_str && (ten_cnt == TW'(US_PER_TICK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_cnt  <= '0;
      ten_cnt <= '0;
    end else if (!run || restart) begin
      us_cnt  <= '0;
      ten_cnt <= '0;
    end else if (us_str) begin
      us_cnt  <= '0;
      ten_cnt <= (ten_cnt == TW'(US_PER_TICK - 1)) ? '0 : ten_cnt + 1'b1;
    end else begin
      us_cnt <= us_cnt + 1'b1;
    end
  end

  // R4: ticks never come back to back
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/irrx_meter.sv
module irrx_meter
  import irrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        armed,
  input  logic        lvl,
  input  logic        tick,
  input  logic [15:0] maxw,
  output logic        restart,
  output logic        push,
  output logic        push_tmo,
  output logic [31:0] word
);
  irrx_state_e state_q;
  logic        lvl_q, fall, rise;
  logic [15:0] mark_q, space_q;

  assign fall    = lvl_q && !lvl;
  assign rise    = !lvl_q && lvl;
  assign restart = armed && (((state_q != ST_MARK) && fall) || ((state_q == ST_MARK) && rise));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      lvl_q    <= 1'b1;
      mark_q   <= '0;
      space_q  <= '0;
      push     <= 1'b0;
      push_tmo <= 1'b0;
      word     <= '0;
    end else begin
      lvl_q    <= lvl;
      push     <= 1'b0;
      push_tmo <= 1'b0;
      if (!armed) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (fall) begin
            state_q <= ST_MARK;
            mark_q  <= '0;
            space_q <= '0;
          end
          ST_MARK: if (rise) begin
            state_q <= ST_SPACE;
          end else if (tick) begin
            if (reaches_max(mark_q + 16'd1, 16'd0, maxw)) begin
              push     <= 1'b1;
              push_tmo <= 1'b1;
              word     <= pack_symbol(mark_q + 16'd1, 16'd0);
              state_q  <= ST_IDLE;
            end else begin
              mark_q <= mark_q + 16'd1;
            end
          end
          ST_SPACE: if (fall) begin
            push    <= 1'b1;
            word    <= pack_symbol(mark_q, space_q);
            state_q <= ST_MARK;
            mark_q  <= '0;
            space_q <= '0;
          end else if (tick) begin
            if (reaches_max(mark_q, space_q + 16'd1, maxw)) begin
              push     <= 1'b1;
              push_tmo <= 1'b1;
              word     <= pack_symbol(mark_q, space_q + 16'd1);
              state_q  <= ST_IDLE;
            end else begin
              space_q <= space_q + 16'd1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R5: an early closure always leaves the receiver idle
  a_r5_tmo_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    push_tmo |-> (state_q == ST_IDLE));
endmodule

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
  parameter int DEPTH = 64,
  parameter int W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, accept, do_pop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign do_pop = pop && !empty;
  assign accept = push && (!full || do_pop);
  assign drop   = push && !accept;
  assign dout   = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(accept) - CW'(do_pop);
    end
  end

  // R8: a dropped push leaves the fill level alone
  a_r8_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));
  // R6: fill level stays within depth
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/ir_symbol_rx.sv
module ir_symbol_rx
  import irrx_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int SETTLE_CYCLES = 16,
  parameter int US_PER_TICK = 10,
  localparam int CW = $clog2(FIFO_DEPTH + 1),
  localparam int BW = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  logic [1:0]    sync_q;
  logic          en_q, armed_q;
  logic [BW-1:0] busy_cnt;
  logic          busy;
  logic [31:0]   cfg_q;
  logic [2:0]    mask_q, flags_q, shown;
  logic          wr, rd, cfg_wr, pop;
  logic          restart, tick, m_push, m_tmo, drop;
  logic [31:0]   m_word, head;
  logic [CW-1:0] count;
  logic          over_level;

  assign wr     = bus_sel && bus_wr;
  assign rd     = bus_sel && !bus_wr;
  assign busy   = (busy_cnt != '0);
  assign cfg_wr = wr && (bus_addr == A_CFG);
  assign pop    = rd && (bus_addr == A_DATA);
  assign shown  = flags_q & ~mask_q;
  assign irq    = |shown;
  assign over_level = 32'(count) > 32'(cfg_q[13:8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], ir_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      armed_q  <= 1'b0;
      busy_cnt <= '0;
      cfg_q    <= CFG_RESET;
      mask_q   <= 3'b111;
      flags_q  <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (wr && bus_addr == A_EN) begin
        en_q <= bus_wdata[0];
        if (bus_wdata[0] && !en_q) busy_cnt <= BW'(SETTLE_CYCLES);
        if (!bus_wdata[0]) armed_q <= 1'b0;
      end
      if (wr && bus_addr == A_START && en_q) armed_q <= 1'b1;
      if (cfg_wr && !busy) cfg_q <= bus_wdata;
      if (wr && bus_addr == A_MASK) mask_q <= bus_wdata[2:0];
      flags_q <= (flags_q & ~((wr && bus_addr == A_CLR) ? bus_wdata[18:16] : 3'b000))
               | {drop, m_push && m_tmo, over_level};
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_EN:    bus_rdata = {31'd0, en_q};
      A_CFG:   bus_rdata = cfg_q;
      A_BUSY:  bus_rdata = {31'd0, busy};
      A_COUNT: bus_rdata = 32'(count);
      A_DATA:  bus_rdata = head;
      A_MASK:  bus_rdata = {29'd0, mask_q};
      A_STAT:  bus_rdata = {5'd0, shown, 13'd0, flags_q, 8'd0};
      default: bus_rdata = '0;
    endcase
  end

  irrx_tickgen #(.US_PER_TICK(US_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(armed_q), .restart(restart),
    .freq_m1(cfg_q[6:0]), .tick(tick));

  irrx_meter u_meter (
    .clk(clk), .rst_n(rst_n), .armed(armed_q), .lvl(sync_q[1]), .tick(tick),
    .maxw(cfg_q[31:16]), .restart(restart), .push(m_push), .push_tmo(m_tmo),
    .word(m_word));

  irrx_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(m_push), .din(m_word), .pop(pop),
    .dout(head), .count(count), .drop(drop));

  // R2: config is frozen while settling
  a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && busy) |=> $stable(cfg_q));
  // R3 / R11: nothing is measured while disarmed
  a_r3_no_push_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !m_push);
  // R8: overflow only rises after a dropped push
  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[2]) |-> $past(drop));
endmodule

// File: tb/ir_symbol_rx_bench.sv
module ir_symbol_rx_bench;
  localparam int DEPTH = 4;
  localparam int SETTLE = 4;
  localparam int MAXW = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_tests = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  ir_symbol_rx #(.FIFO_DEPTH(DEPTH), .SETTLE_CYCLES(SETTLE), .US_PER_TICK(10)) u_ir_symbol_rx (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] sym(input int m, input int s);
    return {16'(s), 16'(m)};
  endfunction

  logic [31:0] v;

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd(8'h00, v); chk("R1 enable", v, 0);
    rd(8'h04, v); chk("R1 config", v, 32'h3E80_0080);
    rd(8'h28, v); chk("R1 mask", v, 7);
    rd(8'h20, v); chk("R1 count", v, 0);
    rd(8'h2C, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    // R2 settling window
    wr(8'h00, 1);
    rd(8'h1C, v); chk("R2 busy high", v, 1);
    wr(8'h04, 32'h1234_0080);
    rd(8'h04, v); chk("R2 cfg ignored while busy", v, 32'h3E80_0080);
    idle(SETTLE + 2);
    rd(8'h1C, v); chk("R2 busy low", v, 0);
    wr(8'h04, {16'(MAXW), 2'b00, 6'd0, 1'b1, 7'd0});
    rd(8'h04, v); chk("R2 cfg accepted", v, {16'(MAXW), 2'b00, 6'd0, 1'b1, 7'd0});
    // R3 not armed yet
    ir_in = 0; idle(30); ir_in = 1; idle(30); ir_in = 0; idle(30); ir_in = 1; idle(30);
    rd(8'h20, v); chk("R3 ignored before start", v, 0);
    wr(8'h34, 0);
    wr(8'h28, 0);
    idle(5);
    // R4 sweep of mark/space pairs
    begin
      int pm = 0, ps = 0;
      bit have = 0;
      for (int m = 1; m <= 6; m++) begin
        for (int s = 1; s <= 6; s++) begin
          ir_in = 0;
          idle(6);
          if (have) begin
            rd(8'h20, v); chk("R6 count one", v, 1);
            rd(8'h24, v); chk("R4 pair", v, sym(pm, ps));
          end
          idle(m * 10 + 5 - 6 - (have ? 2 : 0));
          ir_in = 1;
          idle(s * 10 + 5);
          pm = m; ps = s; have = 1;
        end
      end
      // R5 last symbol closes in space by timeout
      idle((MAXW + 2) * 10);
      rd(8'h20, v); chk("R5 count", v, 1);
      rd(8'h2C, v); chk("R5 status tmo+rcv", v, 32'h0300_0300);
      chk("R10 irq", {31'd0, irq}, 1);
      rd(8'h24, v); chk("R5 space closure", v, sym(6, MAXW - 6));
    end
    // R6 empty read
    rd(8'h24, v); chk("R6 empty data", v, 0);
    rd(8'h20, v); chk("R6 empty count", v, 0);
    // R9 clear
    wr(8'h30, 0);
    rd(8'h2C, v); chk("R9 zero write no effect", v, 32'h0300_0300);
    wr(8'h30, 32'h0002_0000);
    rd(8'h2C, v); chk("R9 clear tmo", v, 32'h0100_0100);
    wr(8'h30, 32'h0001_0000);
    rd(8'h2C, v); chk("R9 clear rcv", v, 0);
    chk("R9 irq low", {31'd0, irq}, 0);
    // R5 mark-phase closure, R10 masking
    ir_in = 0;
    idle((MAXW + 2) * 10);
    wr(8'h28, 3);
    rd(8'h2C, v); chk("R10 all masked", v, 32'h0000_0300);
    chk("R10 irq masked", {31'd0, irq}, 0);
    wr(8'h28, 2);
    rd(8'h2C, v); chk("R10 tmo masked", v, 32'h0100_0300);
    chk("R10 irq rcv", {31'd0, irq}, 1);
    wr(8'h28, 0);
    ir_in = 1;
    idle(20);
    rd(8'h24, v); chk("R5 mark closure", v, sym(MAXW, 0));
    wr(8'h30, 32'h0007_0000);
    rd(8'h2C, v); chk("R9 clear all", v, 0);
    // R7 level, R8 overflow
    wr(8'h04, {16'(MAXW), 2'b00, 6'd2, 1'b1, 7'd0});
    for (int i = 0; i < 6; i++) begin
      ir_in = 0;
      idle(6);
      rd(8'h2C, v);
      if (i == 2) chk("R7 count 2 not above", v & 32'h100, 0);
      if (i == 3) chk("R7 count 3 above", v & 32'h100, 32'h100);
      idle((i + 1) * 10 + 5 - 7);
      ir_in = 1;
      idle(25);
    end
    idle((MAXW + 2) * 10);
    rd(8'h20, v); chk("R8 count full", v, DEPTH);
    rd(8'h2C, v); chk("R8 ovf flag", v & 32'h400, 32'h400);
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h24, v); chk("R8 kept in order", v, sym(i + 1, 2));
    end
    wr(8'h30, 32'h0007_0000);
    rd(8'h2C, v); chk("R9 ovf cleared", v, 0);
    // R11 disarm
    wr(8'h00, 0);
    ir_in = 0; idle(30); ir_in = 1; idle(30); ir_in = 0; idle(30); ir_in = 1; idle(500);
    rd(8'h20, v); chk("R11 no capture disabled", v, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule